// File: doc/BRIEF.md
# Compartment Access Filter

This block decides, for each request, whether a bus initiator may reach one of `NUM_PERIPH` peripherals. A request gives a peripheral index, the initiator's 3-bit compartment identifier (CID), its secure attribute, and the present state of that peripheral's semaphore: whether it is held, and by which CID. The block checks the request against a bank of per-peripheral configuration registers. One clock later it reports grant or deny together with a reason code. A denied request also raises a one-cycle error pulse that carries the offending index.

The configuration is written through a write-only register port. That port holds three kinds of state. The first is one CID word per peripheral, with a filter enable, a semaphore-mode enable, a static CID and an eight-bit CID whitelist. The second is a set of secure-only words, each packing 32 peripherals. The third is an entry-limit register that marks indices beyond it as invalid. The checks have a fixed priority. Semaphore mode replaces the static CID. A static CID of zero admits every compartment. The security check comes after the CID check, and semaphore ownership is checked last.

The control is a three-state machine. `IDLE` means no response is pending. `GRANT` and `DENY` each present the decision for the previous cycle's request. There are two transitions. A request in any state moves the machine to `GRANT` or `DENY`, chosen by the evaluated reason. A cycle with no request moves it to `IDLE`. Back-to-back requests therefore produce a response every cycle.

Top module: `acf_filter`

## Requirements
- R1: A request sampled on `req_valid` at a rising edge produces `rsp_valid` high for exactly the next clock cycle. Requests may arrive on consecutive cycles, and a cycle with no request produces no response.
- R2: An index that is at or above the entry limit is denied with reason 1 (bad index). The entry limit is the smaller of the limit register and `NUM_PERIPH`. This check takes priority over every other check.
- R3: The CID check passes for any initiator CID when filtering is off (CID word bit 0 clear), and also when filtering is on without semaphore mode and the static CID (bits 6:4) is 0. Semaphore enable (bit 1) has no effect while bit 0 is clear.
- R4: With filtering on, semaphore mode off and a nonzero static CID, a request whose CID differs from the static CID is denied with reason 2.
- R5: With filtering and semaphore mode both on, the static CID is ignored. The request passes the CID check only if whitelist bit 16+k is set for its CID k. Otherwise it is denied with reason 3.
- R6: If the peripheral's secure-only bit is set and the request is non-secure, the request is denied with reason 4. Peripheral i uses bit i%32 of secure word i/32. A request that fails the CID check reports the CID reason, not reason 4.
- R7: In semaphore mode, a request that passes the earlier checks is granted only when the semaphore is held and its owner equals the requesting CID. Otherwise it is denied with reason 5.
- R8: A grant reports reason 0 and raises no error pulse. A deny raises `err_pulse` for that single response cycle, with `err_idx` equal to the request's index.
- R9: `cfg_space` selects the target of a write. 0 writes the CID word of peripheral `cfg_index`. 1 writes secure word `cfg_index`. 2 writes the limit register from the low bits of the data. 3 has no effect. CID-word bits outside 0, 1, 6:4 and 23:16 are ignored. A write in the same cycle as a request affects only later requests.
- R10: Reset clears every CID word and secure word, sets the limit to `NUM_PERIPH` and holds all response outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_space | input | 2 | Write target select (R9 encoding) |
| cfg_index | input | IDX_W | Peripheral or secure-word index of the write |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| req_idx | input | IDX_W | Target peripheral index |
| req_cid | input | 3 | Initiator compartment ID |
| req_secure | input | 1 | Initiator secure attribute |
| sem_held | input | 1 | The semaphore of the target peripheral is held |
| sem_owner | input | 3 | CID holding that semaphore |
| rsp_valid | output | 1 | A decision is presented this cycle |
| rsp_grant | output | 1 | The decision is a grant |
| rsp_reason | output | 3 | Reason code (0 grant, 1 to 5 deny) |
| err_pulse | output | 1 | One-cycle illegal-access pulse |
| err_idx | output | IDX_W | Index of the denied request |

## Verification
Every decision, together with its reason, error pulse and error index, is due one clock after the rising edge that samples `req_valid`. A configuration write changes the decision only for requests sampled after its own edge. The driver stamps each expected item with the cycle count at which it drives the request. The monitor samples on the falling edge and expects a response exactly when the oldest queued item carries the previous cycle's stamp. Every other cycle is checked for silence.

// File: rtl/acf_pkg.sv
package acf_pkg;
    localparam int CID_W        = 3;
    localparam int NUM_CID      = 1 << CID_W;
    localparam int WORD_W       = 32;
    localparam int BITS_PER_SEC = 32;
    localparam int FEN_BIT      = 0;
    localparam int SEN_BIT      = 1;
    localparam int SCID_LSB     = 4;
    localparam int WL_LSB       = 16;

    typedef struct packed {
        logic [NUM_CID-1:0] wl;
        logic [CID_W-1:0]   scid;
        logic               sem_en;
        logic               filt_en;
    } cid_cfg_t;

    typedef enum logic [2:0] {
        RSN_OK           = 3'd0,
        RSN_BAD_INDEX    = 3'd1,
        RSN_CID_MISMATCH = 3'd2,
        RSN_NOT_LISTED   = 3'd3,
        RSN_SECURE_ONLY  = 3'd4,
        RSN_SEM_NOT_OWN  = 3'd5
    } reason_e;

    typedef enum logic [1:0] {
        SPACE_CID   = 2'd0,
        SPACE_SEC   = 2'd1,
        SPACE_LIMIT = 2'd2,
        SPACE_NONE  = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_GRANT = 2'd1,
        S_DENY  = 2'd2
    } fsm_e;
endpackage

// File: rtl/acf_cfg_bank.sv
module acf_cfg_bank
    import acf_pkg::*;
#(
    parameter int NUM_PERIPH = 40,
    parameter int IDX_W      = 6,
    parameter int SEC_WORDS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        space,
    input  logic [IDX_W-1:0]  index,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output cid_cfg_t          rd_cfg,
    output logic              rd_secure,
    output logic [IDX_W-1:0]  rd_limit
);
    cid_cfg_t          wr_cfg;
    cid_cfg_t          cfg_q [NUM_PERIPH];
    logic [WORD_W-1:0] sec_q [SEC_WORDS];
    logic [IDX_W-1:0]  lim_q;
    logic              wr_cid, wr_sec, wr_lim;
    logic [4:0]        bit_sel;

    // Only the decoded fields of a CID word are kept.
    always_comb begin
        wr_cfg.filt_en = wdata[FEN_BIT];
        wr_cfg.sem_en  = wdata[SEN_BIT];
        wr_cfg.scid    = wdata[SCID_LSB +: CID_W];
        wr_cfg.wl      = wdata[WL_LSB +: NUM_CID];
        wr_cid = we && (space_e'(space) == SPACE_CID);
        wr_sec = we && (space_e'(space) == SPACE_SEC);
        wr_lim = we && (space_e'(space) == SPACE_LIMIT);
    end

    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_cid
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[p] <= '0;
            end else if (wr_cid && index == IDX_W'(p)) begin
                cfg_q[p] <= wr_cfg;
            end
        end
    end

    for (genvar w = 0; w < SEC_WORDS; w++) begin : g_sec
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sec_q[w] <= '0;
            end else if (wr_sec && index == IDX_W'(w)) begin
                sec_q[w] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= IDX_W'(NUM_PERIPH);
        end else if (wr_lim) begin
            lim_q <= wdata[IDX_W-1:0];
        end
    end

    // Read side: compare-and-select over entries so no index runs out of range.
    always_comb begin
        rd_cfg = '0;
        for (int p = 0; p < NUM_PERIPH; p++) begin
            if (rd_idx == IDX_W'(p)) rd_cfg = cfg_q[p];
        end
    end

    always_comb begin
        bit_sel   = 5'(rd_idx);
        rd_secure = 1'b0;
        for (int w = 0; w < SEC_WORDS; w++) begin
            if ((int'(rd_idx) >> 5) == w) rd_secure = sec_q[w][bit_sel];
        end
    end

    assign rd_limit = lim_q;
endmodule

// File: rtl/acf_rule_eval.sv
module acf_rule_eval
    import acf_pkg::*;
#(
    parameter int NUM_PERIPH = 40,
    parameter int IDX_W      = 6
) (
    input  cid_cfg_t          cfg,
    input  logic              secure_only,
    input  logic [IDX_W-1:0]  limit,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CID_W-1:0]  cid,
    input  logic              req_secure,
    input  logic              sem_held,
    input  logic [CID_W-1:0]  sem_owner,
    output reason_e           reason
);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_PERIPH);

    logic [IDX_W-1:0] limit_eff;
    logic             sem_mode;
    logic             static_hit;

    always_comb begin
        limit_eff  = (limit > MAX_IDX) ? MAX_IDX : limit;
        sem_mode   = cfg.filt_en && cfg.sem_en;
        static_hit = (cfg.scid == '0) || (cfg.scid == cid);
        // Priority: index, CID, security, semaphore ownership.
        if (idx >= limit_eff) begin
            reason = RSN_BAD_INDEX;
        end else if (sem_mode && !cfg.wl[cid]) begin
            reason = RSN_NOT_LISTED;
        end else if (!sem_mode && cfg.filt_en && !static_hit) begin
            reason = RSN_CID_MISMATCH;
        end else if (secure_only && !req_secure) begin
            reason = RSN_SECURE_ONLY;
        end else if (sem_mode && !(sem_held && sem_owner == cid)) begin
            reason = RSN_SEM_NOT_OWN;
        end else begin
            reason = RSN_OK;
        end
    end
endmodule

// File: rtl/acf_filter.sv
module acf_filter
    import acf_pkg::*;
#(
    parameter  int NUM_PERIPH = 40,
    localparam int IDX_W      = $clog2(NUM_PERIPH + 1),
    localparam int SEC_WORDS  = (NUM_PERIPH + BITS_PER_SEC - 1) / BITS_PER_SEC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_space,
    input  logic [IDX_W-1:0]  cfg_index,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [CID_W-1:0]  req_cid,
    input  logic              req_secure,
    input  logic              sem_held,
    input  logic [CID_W-1:0]  sem_owner,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [2:0]        rsp_reason,
    output logic              err_pulse,
    output logic [IDX_W-1:0]  err_idx
);
    cid_cfg_t         sel_cfg;
    logic             sel_secure;
    logic [IDX_W-1:0] sel_limit;
    reason_e          eval_reason;
    fsm_e             state_q, state_d;
    reason_e          reason_q;
    logic [IDX_W-1:0] err_idx_q;

    acf_cfg_bank #(
        .NUM_PERIPH (NUM_PERIPH),
        .IDX_W      (IDX_W),
        .SEC_WORDS  (SEC_WORDS)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .space     (cfg_space),
        .index     (cfg_index),
        .wdata     (cfg_wdata),
        .rd_idx    (req_idx),
        .rd_cfg    (sel_cfg),
        .rd_secure (sel_secure),
        .rd_limit  (sel_limit)
    );

    acf_rule_eval #(
        .NUM_PERIPH (NUM_PERIPH),
        .IDX_W      (IDX_W)
    ) i_eval (
        .cfg         (sel_cfg),
        .secure_only (sel_secure),
        .limit       (sel_limit),
        .idx         (req_idx),
        .cid         (req_cid),
        .req_secure  (req_secure),
        .sem_held    (sem_held),
        .sem_owner   (sem_owner),
        .reason      (eval_reason)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = (eval_reason == RSN_OK) ? S_GRANT : S_DENY;
            S_GRANT: state_d = !req_valid ? S_IDLE
                             : (eval_reason == RSN_OK) ? S_GRANT : S_DENY;
            S_DENY:  state_d = !req_valid ? S_IDLE
                             : (eval_reason == RSN_OK) ? S_GRANT : S_DENY;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            reason_q  <= RSN_OK;
            err_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) reason_q <= eval_reason;
            if (req_valid && eval_reason != RSN_OK) err_idx_q <= req_idx;
        end
    end

    always_comb begin
        rsp_valid  = (state_q != S_IDLE);
        rsp_grant  = (state_q == S_GRANT);
        err_pulse  = (state_q == S_DENY);
        rsp_reason = rsp_valid ? reason_q : RSN_OK;
        err_idx    = err_idx_q;
    end
endmodule

// File: rtl/acf_filter_chk.sv
module acf_filter_chk
#(
    parameter  int NUM_PERIPH = 40,
    localparam int IDX_W      = $clog2(NUM_PERIPH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_idx,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic [2:0]       rsp_reason,
    input logic             err_pulse,
    input logic [IDX_W-1:0] err_idx
);
    p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_bad_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_idx >= IDX_W'(NUM_PERIPH)) |=> (!rsp_grant && rsp_reason == 3'd1));

    p_deny_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_grant) |-> (err_pulse && err_idx == $past(req_idx)));

    p_grant_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> (rsp_valid && !err_pulse && rsp_reason == 3'd0));

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && !req_valid) |=> !err_pulse);

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |-> (!rsp_valid && !err_pulse));
endmodule

bind acf_filter acf_filter_chk #(.NUM_PERIPH(NUM_PERIPH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_idx    (req_idx),
    .rsp_valid  (rsp_valid),
    .rsp_grant  (rsp_grant),
    .rsp_reason (rsp_reason),
    .err_pulse  (err_pulse),
    .err_idx    (err_idx)
);

// File: tb/test_acf_filter.sv
`timescale 1ns/1ps
module test_acf_filter;
    localparam int NP = 40;
    localparam int IW = $clog2(NP + 1);

    typedef struct {
        int    stamp;
        int    reason;
        int    idx;
        string tag;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_space = '0;
    logic [IW-1:0] cfg_index = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_idx = '0;
    logic [2:0]    req_cid = '0;
    logic          req_secure = 1'b0;
    logic          sem_held = 1'b0;
    logic [2:0]    sem_owner = '0;
    logic          rsp_valid, rsp_grant, err_pulse;
    logic [2:0]    rsp_reason;
    logic [IW-1:0] err_idx;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    exp_item_t sb[$];

    logic [31:0] m_word [NP];
    logic [31:0] m_sec [2];
    int          m_lim;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    acf_filter #(.NUM_PERIPH(NP)) i_acf_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_space(cfg_space),
        .cfg_index(cfg_index), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_idx(req_idx), .req_cid(req_cid), .req_secure(req_secure),
        .sem_held(sem_held), .sem_owner(sem_owner), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .rsp_reason(rsp_reason), .err_pulse(err_pulse),
        .err_idx(err_idx)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_reason(int idx, int cid, bit sec, bit held, int owner);
        int lim;
        logic [31:0] w;
        bit fe, se;
        int scid;
        lim = (m_lim > NP) ? NP : m_lim;
        if (idx >= lim) return 1;
        w = m_word[idx];
        fe = w[0];
        se = w[1];
        scid = int'(w[6:4]);
        if (fe && se) begin
            if (!w[16 + cid]) return 3;
        end else if (fe && scid != 0 && scid != cid) begin
            return 2;
        end
        if (m_sec[idx / 32][idx % 32] && !sec) return 4;
        if (fe && se && !(held && owner == cid)) return 5;
        return 0;
    endfunction

    function automatic void model_write(int space, int index, logic [31:0] data);
        case (space)
            0: if (index < NP) m_word[index] = data;
            1: if (index < 2) m_sec[index] = data;
            2: m_lim = int'(data) % (1 << IW);
            default: ;
        endcase
    endfunction

    task automatic push_exp(int idx, int cid, bit sec, bit held, int owner, string tag);
        exp_item_t it;
        it.stamp  = cyc;
        it.reason = model_reason(idx, cid, sec, held, owner);
        it.idx    = idx;
        it.tag    = tag;
        sb.push_back(it);
    endtask

    task automatic set_req(int idx, int cid, bit sec, bit held, int owner);
        req_valid  = 1'b1;
        req_idx    = IW'(idx);
        req_cid    = 3'(cid);
        req_secure = sec;
        sem_held   = held;
        sem_owner  = 3'(owner);
    endtask

    task automatic drive_req(int idx, int cid, bit sec, bit held, int owner, string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        set_req(idx, cid, sec, held, owner);
        push_exp(idx, cid, sec, held, owner, tag);
    endtask

    task automatic drive_wr(int space, int index, logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_space = 2'(space);
        cfg_index = IW'(index);
        cfg_wdata = data;
        model_write(space, index, data);
    endtask

    task automatic drive_wr_req(int space, int index, logic [31:0] data,
                                int idx, int cid, bit sec, bit held, int owner, string tag);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_space = 2'(space);
        cfg_index = IW'(index);
        cfg_wdata = data;
        set_req(idx, cid, sec, held, owner);
        push_exp(idx, cid, sec, held, owner, tag);
        model_write(space, index, data);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            cfg_we    = 1'b0;
        end
    endtask

    // Monitor: a response is due one cycle after the cycle its request was driven in.
    always @(negedge clk) begin
        if (rst_n) begin
            bit due;
            due = (sb.size() > 0) && (sb[0].stamp == cyc - 1);
            if (due) begin
                exp_item_t it;
                it = sb.pop_front();
                chk(rsp_valid == 1'b1, {it.tag, " R1"}, "rsp_valid", int'(rsp_valid), 1);
                chk(int'(rsp_reason) == it.reason, it.tag, "reason", int'(rsp_reason), it.reason);
                chk(rsp_grant == (it.reason == 0), it.tag, "grant", int'(rsp_grant),
                    int'(it.reason == 0));
                chk(err_pulse == (it.reason != 0), {it.tag, " R8"}, "err_pulse", int'(err_pulse),
                    int'(it.reason != 0));
                if (it.reason != 0)
                    chk(int'(err_idx) == it.idx, {it.tag, " R8"}, "err_idx", int'(err_idx), it.idx);
            end else begin
                chk(!rsp_valid && !err_pulse, "R1", "idle response", int'(rsp_valid), 0);
            end
        end
    end

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) m_word[i] = '0;
        m_sec[0] = '0;
        m_sec[1] = '0;
        m_lim = NP;
        repeat (3) @(negedge clk);
        // R10: reset state of outputs while held in reset
        chk(!rsp_valid && !rsp_grant && !err_pulse && rsp_reason == 3'd0, "R10",
            "outputs in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        idle(2);

        // R10: default limit is NP, default config admits everything
        drive_req(NP - 1, 0, 0, 0, 0, "R10");
        drive_req(NP, 0, 0, 0, 0, "R10 R2");
        // R3: filtering off by default, any CID
        drive_req(0, 7, 0, 0, 0, "R3");
        drive_req(20, 3, 1, 0, 0, "R3");
        idle(1);

        // R2: index bounds, limit register
        drive_req(63, 1, 1, 1, 1, "R2");
        drive_wr(2, 0, 32'd10);
        drive_req(10, 1, 0, 0, 0, "R2");
        drive_req(9, 1, 0, 0, 0, "R2");
        drive_wr(2, 0, 32'd63);
        drive_req(39, 1, 0, 0, 0, "R2");
        drive_req(40, 1, 0, 0, 0, "R2");
        idle(1);

        // R3: filter on, static CID 0 is a wildcard
        drive_wr(0, 3, 32'h0000_0001);
        drive_req(3, 6, 0, 0, 0, "R3");
        // R4 and R9: static CID 5, junk bits 2 and 31 ignored
        drive_wr(0, 3, 32'h8000_0055);
        drive_req(3, 5, 0, 0, 0, "R4 R9");
        drive_req(3, 2, 0, 0, 0, "R4");
        drive_req(3, 0, 0, 0, 0, "R4");
        idle(1);

        // R5, R7: semaphore mode, static CID 5 ignored, whitelist CIDs 1 and 6
        drive_wr(0, 7, 32'h0042_0053);
        drive_req(7, 5, 0, 1, 5, "R5");
        drive_req(7, 0, 0, 1, 0, "R5");
        drive_req(7, 1, 0, 1, 1, "R7");
        drive_req(7, 1, 0, 1, 2, "R7");
        drive_req(7, 6, 0, 0, 6, "R7");
        drive_req(7, 6, 0, 1, 6, "R7");
        idle(1);

        // R3: semaphore enable without filtering has no effect
        drive_wr(0, 8, 32'h0000_0002);
        drive_req(8, 4, 0, 0, 0, "R3");

        // R6: secure word 1 bit 3 is peripheral 35
        drive_wr(1, 1, 32'h0000_0008);
        drive_req(35, 2, 0, 0, 0, "R6");
        drive_req(35, 2, 1, 0, 0, "R6");
        // R6: peripheral 7 secure-only, checked before semaphore, after CID
        drive_wr(1, 0, 32'h0000_0080);
        drive_req(7, 1, 0, 1, 1, "R6");
        drive_req(7, 1, 1, 1, 1, "R6");
        drive_req(7, 5, 0, 1, 5, "R6");
        drive_wr(0, 35, 32'h0000_0031);
        drive_req(35, 4, 0, 0, 0, "R6");
        idle(1);

        // R1, R8: back-to-back mix of deny and grant
        drive_req(3, 2, 0, 0, 0, "R8");
        drive_req(3, 5, 0, 0, 0, "R8");
        drive_req(50, 5, 0, 0, 0, "R8");
        drive_req(0, 5, 0, 0, 0, "R1");
        idle(2);

        // R9: same-cycle write uses old config; space 3 has no effect
        drive_wr_req(0, 3, 32'h0000_0000, 3, 2, 0, 0, 0, "R9");
        drive_req(3, 2, 0, 0, 0, "R9");
        drive_wr(3, 3, 32'hFFFF_FFFF);
        drive_req(3, 2, 0, 0, 0, "R9");
        drive_req(7, 1, 1, 1, 1, "R9");
        idle(3);

        chk(sb.size() == 0, "R1", "pending responses", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule